// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block keeps an external serial delta-sigma converter busy by walking through up to six analog channels and keeping the newest sample of each one in a register bank on a 16-bit host bus. Channels 1 and 2 are differential inputs with a ±2.048 V span. Channels 3 to 6 are single-ended inputs with a 0 to 10.24 V span. The single-ended inputs share two converter inputs through an external analog multiplexer. The sequencer drives that multiplexer's select line, and the select line can be routed to either of two board pins or left undriven.

Software writes a configuration word, which sets gain, conversion rate and select routing, and a channel enable mask. It then reads the six result registers whenever it likes. Enabled channels are converted in turn, so each channel's sample rate drops as more channels are enabled. Each conversion goes out as a request on a request/acknowledge command port, which the transport that actually talks to the converter serves. The acknowledge returns a 16-bit result. For differential channels at the two lower resolutions, the result is sign-extended before it is stored.

Top module: `adc_scan_seq`

## Requirements
- R1: The word at bus index 0 reads as {8'hAD, 2'b00, route[1:0], rate[1:0], gain[1:0]}. The three fields are written from write-data bits 5:4, 3:2 and 1:0. Bits 15:6 written there are dropped. The mask word at bus index 1 stores and returns all 16 written bits. Result registers for channels 1..6 sit at bus indices 2..7. After reset, every register other than the identifier byte reads zero.
- R2: Channels whose mask bit (bit k-1 for channel k) is set are converted in ascending order, wrapping from channel 6 to channel 1. The first channel after reset is the lowest enabled one.
- R3: While mask bits 5:0 are all zero, no request is issued. Mask bits 15:6 never enable anything.
- R4: The result register of a channel that is not converted keeps its previous value.
- R5: cmd_chan selects the converter input as follows: channel 1 gives 0, channel 2 gives 1, channels 3 and 5 give 2, and channels 4 and 6 give 3.
- R6: The select level is high for channels 5 and 6 and low otherwise. Route 1 puts it on sel_pin_a, route 2 puts it on sel_pin_b, and routes 0 and 3 leave both pins low. The two pins are never both high.
- R7: The select pins are set when a channel is chosen. At least SETTLE_CYC quiet clocks pass before cmd_req rises. Between two back-to-back conversions, cmd_req is low for exactly SETTLE_CYC+1 clocks. cmd_req and the pins hold until cmd_ack.
- R8: cmd_gain and cmd_rate carry the gain and rate fields as they stood when the channel was chosen. A configuration or mask write made while a request is outstanding changes only the following requests.
- R9: On the clock where cmd_ack is seen with cmd_req high, the result is written in one step into the register of the channel that was requested, even if the mask changed meanwhile.
- R10: For channels 1 and 2, rate 0 replaces bits 15:12 with copies of bit 11, and rate 1 replaces bits 15:14 with copies of bit 13. Rate 2, and every single-ended channel, store the 16 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 3 | Host word index (byte offset / 2) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from bus_addr |
| cmd_req | output | 1 | Conversion request, held until acknowledged |
| cmd_chan | output | 2 | Converter input select |
| cmd_gain | output | 2 | Gain code forwarded with the request |
| cmd_rate | output | 2 | Rate/resolution code forwarded with the request |
| cmd_ack | input | 1 | One-clock acknowledge carrying the result |
| cmd_result | input | 16 | Raw conversion result, valid with cmd_ack |
| sel_pin_a | output | 1 | Analog select on board pin A |
| sel_pin_b | output | 1 | Analog select on board pin B |

## Verification
A host write is sampled on the next rising edge, so it has effect from the clock after the write strobe. A result register can be read on the clock after the acknowledge. A new request rises SETTLE_CYC+1 clocks after the previous acknowledge when the scan keeps running. The bench drives and samples on falling edges. Before it reads the registers, it waits one more falling edge after the acknowledge it has counted. It writes mask and configuration only while a request is outstanding, or while the scan is idle, so the channel and the fields it predicts for each request are settled before the choice is made. At the start of every request it checks the gap since the previous request against the SETTLE_CYC+1 minimum.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam logic [7:0] CORE_ID = 8'hAD;
   localparam int unsigned NUM_DIFF = 2;
   localparam int unsigned NUM_SE = 4;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_REQ    = 2'd2
   } scan_state_t;

   typedef struct packed {
      logic [1:0] route;
      logic [1:0] rate;
      logic [1:0] gain;
   } scan_cfg_t;

   // converter input used by a zero-based channel index
   function automatic logic [1:0] conv_input(input int unsigned idx);
      if (idx < NUM_DIFF) return 2'(idx);
      return 2'(NUM_DIFF + ((idx - NUM_DIFF) % 2));
   endfunction

   // external mux level: upper pair of single-ended channels selects high
   function automatic logic sel_high(input int unsigned idx);
      return idx >= (NUM_DIFF + NUM_SE / 2);
   endfunction

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
   import adc_scan_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 3,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic                     res_we,
   input  logic [CH_W-1:0]          res_idx,
   input  logic [DATA_W-1:0]        res_data,
   output scan_cfg_t                cfg,
   output logic [DATA_W-1:0]        mask
);

   localparam int CFG_W = $bits(scan_cfg_t);
   localparam int PAD_W = DATA_W - 8 - CFG_W;

   scan_cfg_t                      cfg_q;
   logic [DATA_W-1:0]              mask_q;
   logic [NUM_CH-1:0][DATA_W-1:0]  res_q;
   logic [NUM_CH-1:0]              ch_we;

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_we
         assign ch_we[gc] = res_we && (res_idx == CH_W'(gc));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(0)) cfg_q <= scan_cfg_t'(bus_wdata[CFG_W-1:0]);
         if (bus_addr == ADDR_W'(1)) mask_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_we[i]) res_q[i] <= res_data;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(0)) bus_rdata = {CORE_ID, {PAD_W{1'b0}}, cfg_q};
      if (bus_addr == ADDR_W'(1)) bus_rdata = mask_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(i + 2)) bus_rdata = res_q[i];
      end
   end

   assign cfg  = cfg_q;
   assign mask = mask_q;

endmodule

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
   parameter int NUM_CH = 6,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] en,
   input  logic [CH_W-1:0]   last_idx,
   output logic              any,
   output logic [CH_W-1:0]   next_idx
);

   // walk from the farthest candidate to the nearest so the nearest wins
   always_comb begin
      any      = 1'b0;
      next_idx = '0;
      for (int k = NUM_CH; k >= 1; k--) begin
         int c;
         c = (int'(last_idx) + k) % NUM_CH;
         if (en[c]) begin
            any      = 1'b1;
            next_idx = CH_W'(c);
         end
      end
   end

endmodule

// File: rtl/adc_scan_fmt.sv
module adc_scan_fmt #(
   parameter int DATA_W   = 16,
   parameter int LO_BITS  = 12,
   parameter int MID_BITS = 14
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [1:0]        rate,
   input  logic              is_diff,
   output logic [DATA_W-1:0] val
);

   localparam int LO_PAD  = DATA_W - LO_BITS;
   localparam int MID_PAD = DATA_W - MID_BITS;

   generate
      if (!(LO_BITS > 0 && LO_BITS < MID_BITS && MID_BITS < DATA_W)) begin : g_bad_res
         $error("adc_scan_fmt: resolutions must satisfy 0 < LO < MID < DATA_W");
      end
   endgenerate

   always_comb begin
      val = raw;
      if (is_diff) begin
         case (rate)
            2'd0:    val = {{LO_PAD{raw[LO_BITS-1]}}, raw[LO_BITS-1:0]};
            2'd1:    val = {{MID_PAD{raw[MID_BITS-1]}}, raw[MID_BITS-1:0]};
            default: val = raw;
         endcase
      end
   end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH     = 6,
   parameter int SETTLE_CYC = 8,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  scan_cfg_t        cfg,
   input  logic             pick_any,
   input  logic [CH_W-1:0]  pick_idx,
   output logic [CH_W-1:0]  last_idx,
   input  logic             cmd_ack,
   output logic             cmd_req,
   output logic [1:0]       cmd_chan,
   output logic [1:0]       cmd_gain,
   output logic [1:0]       cmd_rate,
   output logic             sel_a,
   output logic             sel_b,
   output logic             res_we,
   output logic [CH_W-1:0]  res_idx
);

   scan_state_t      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CH_W-1:0]  cur_q;
   logic [CH_W-1:0]  last_q;
   scan_cfg_t        lat_q;
   logic             sel_a_q, sel_b_q;
   logic             lvl;

   assign lvl = sel_high(32'(pick_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         cur_q   <= '0;
         last_q  <= CH_W'(NUM_CH - 1);
         lat_q   <= '0;
         sel_a_q <= 1'b0;
         sel_b_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (pick_any) begin
                  cur_q   <= pick_idx;
                  lat_q   <= cfg;
                  sel_a_q <= (cfg.route == 2'd1) && lvl;
                  sel_b_q <= (cfg.route == 2'd2) && lvl;
                  cnt_q   <= CNT_W'(SETTLE_CYC - 1);
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (cnt_q == '0) state_q <= ST_REQ;
               else cnt_q <= cnt_q - 1'b1;
            end
            ST_REQ: begin
               if (cmd_ack) begin
                  last_q  <= cur_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_req  = (state_q == ST_REQ);
   assign cmd_chan = conv_input(32'(cur_q));
   assign cmd_gain = lat_q.gain;
   assign cmd_rate = lat_q.rate;
   assign sel_a    = sel_a_q;
   assign sel_b    = sel_b_q;
   assign res_we   = cmd_req && cmd_ack;
   assign res_idx  = cur_q;
   assign last_idx = last_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int NUM_CH     = 6,
   parameter int ADDR_W     = 3,
   parameter int SETTLE_CYC = 8,
   parameter int LO_BITS    = 12,
   parameter int MID_BITS   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cmd_req,
   output logic [1:0]        cmd_chan,
   output logic [1:0]        cmd_gain,
   output logic [1:0]        cmd_rate,
   input  logic              cmd_ack,
   input  logic [DATA_W-1:0] cmd_result,
   output logic              sel_pin_a,
   output logic              sel_pin_b
);

   localparam int CH_W = $clog2(NUM_CH);

   generate
      if (NUM_CH != NUM_DIFF + NUM_SE) begin : g_bad_ch
         $error("adc_scan_seq: NUM_CH must equal differential plus single-ended count");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("adc_scan_seq: SETTLE_CYC must be at least 1");
      end
      if (DATA_W != 16) begin : g_bad_w
         $error("adc_scan_seq: DATA_W must be 16");
      end
      if ((1 << ADDR_W) < NUM_CH + 2) begin : g_bad_addr
         $error("adc_scan_seq: ADDR_W too small for the register bank");
      end
   endgenerate

   scan_cfg_t         cfg;
   logic [DATA_W-1:0] mask_q;
   logic              pick_any;
   logic [CH_W-1:0]   pick_idx;
   logic [CH_W-1:0]   last_idx;
   logic              res_we;
   logic [CH_W-1:0]   res_idx;
   logic [DATA_W-1:0] res_val;
   logic              is_diff;

   adc_scan_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .res_we(res_we), .res_idx(res_idx), .res_data(res_val),
      .cfg(cfg), .mask(mask_q)
   );

   adc_scan_pick #(.NUM_CH(NUM_CH)) u_pick (
      .en(mask_q[NUM_CH-1:0]), .last_idx(last_idx),
      .any(pick_any), .next_idx(pick_idx)
   );

   adc_scan_ctrl #(.NUM_CH(NUM_CH), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg(cfg),
      .pick_any(pick_any), .pick_idx(pick_idx), .last_idx(last_idx),
      .cmd_ack(cmd_ack), .cmd_req(cmd_req), .cmd_chan(cmd_chan),
      .cmd_gain(cmd_gain), .cmd_rate(cmd_rate),
      .sel_a(sel_pin_a), .sel_b(sel_pin_b),
      .res_we(res_we), .res_idx(res_idx)
   );

   assign is_diff = res_idx < CH_W'(NUM_DIFF);

   adc_scan_fmt #(.DATA_W(DATA_W), .LO_BITS(LO_BITS), .MID_BITS(MID_BITS)) u_fmt (
      .raw(cmd_result), .rate(cmd_rate), .is_diff(is_diff), .val(res_val)
   );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int SETTLE_CYC = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_req,
   input logic       cmd_ack,
   input logic [1:0] cmd_chan,
   input logic [1:0] cmd_gain,
   input logic [1:0] cmd_rate,
   input logic       sel_pin_a,
   input logic       sel_pin_b,
   input logic       res_we
);

   localparam int QW = $clog2(SETTLE_CYC + 2) + 1;
   localparam logic [QW-1:0] QMAX = {QW{1'b1}};

   logic [QW-1:0] quiet_q;

   always_ff @(posedge clk) begin
      if (!rst_n) quiet_q <= '0;
      else if (cmd_req) quiet_q <= '0;
      else if (quiet_q != QMAX) quiet_q <= quiet_q + 1'b1;
   end

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !cmd_ack |=> cmd_req);

   assert_pins_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !cmd_ack |=> $stable(sel_pin_a) && $stable(sel_pin_b));

   assert_settle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_req) |-> quiet_q >= QW'(SETTLE_CYC));

   assert_fields_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !cmd_ack |=> $stable(cmd_chan) && $stable(cmd_gain) && $stable(cmd_rate));

   assert_pins_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_pin_a && sel_pin_b));

   assert_write_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> cmd_req && cmd_ack);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_ack(cmd_ack),
   .cmd_chan(cmd_chan), .cmd_gain(cmd_gain), .cmd_rate(cmd_rate),
   .sel_pin_a(sel_pin_a), .sel_pin_b(sel_pin_b), .res_we(res_we)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

   localparam int S       = 4;
   localparam int ACK_DLY = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cmd_req;
   logic [1:0]  cmd_chan, cmd_gain, cmd_rate;
   logic        cmd_ack = 1'b0;
   logic [15:0] cmd_result = '0;
   logic        sel_pin_a, sel_pin_b;

   int n_tests = 0, n_fail = 0;
   int req_cnt = 0, ack_cnt = 0;
   bit busy = 0;
   int dly = 0, gap = 100;
   int model_last = 5, cur_ch = 0;
   logic [1:0] cur_code, cur_gain, cur_rate;
   logic [15:0] stub_base = 16'h1200;
   logic [15:0] exp_res [6];
   logic [15:0] b_cfg = '0, b_mask = '0;

   adc_scan_seq #(.SETTLE_CYC(S)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_req(cmd_req),
      .cmd_chan(cmd_chan), .cmd_gain(cmd_gain), .cmd_rate(cmd_rate),
      .cmd_ack(cmd_ack), .cmd_result(cmd_result),
      .sel_pin_a(sel_pin_a), .sel_pin_b(sel_pin_b)
   );

   always #10 clk = ~clk;

   task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [1:0] code_of(input int ch);
      if (ch < 2) return 2'(ch);
      return 2'(2 + ((ch - 2) % 2));
   endfunction

   function automatic logic [15:0] bfmt(input logic [15:0] r, input int ch, input logic [1:0] rate);
      if (ch < 2 && rate == 2'd0) return {{4{r[11]}}, r[11:0]};
      if (ch < 2 && rate == 2'd1) return {{2{r[13]}}, r[13:0]};
      return r;
   endfunction

   // converter stub and per-request monitor
   always @(negedge clk) begin
      if (rst_n) begin
         cmd_ack = 1'b0;
         if (busy) begin
            chk("R8", "chan held", {14'b0, cmd_chan}, {14'b0, cur_code});
            chk("R8", "gain held", {14'b0, cmd_gain}, {14'b0, cur_gain});
            chk("R7", "req held", {15'b0, cmd_req}, 16'd1);
            if (dly == 0) begin
               cmd_result = stub_base + 16'(cur_ch << 4);
               cmd_ack = 1'b1;
               exp_res[cur_ch] = bfmt(cmd_result, cur_ch, cur_rate);
               ack_cnt++;
               busy = 0;
            end else dly--;
         end else if (cmd_req) begin
            int e;
            int m;
            req_cnt++;
            m = int'(b_mask[5:0]);
            e = -1;
            if (m == 0) begin
               n_tests++; n_fail++;
               $display("FAIL R3 request with empty mask: actual 1 expected 0");
            end else begin
               for (int k = 6; k >= 1; k--) begin
                  int c;
                  c = (model_last + k) % 6;
                  if (m[c]) e = c;
               end
            end
            if (e >= 0) begin
               logic lv;
               lv = (e >= 4);
               chk("R2/R5", "cmd_chan", {14'b0, cmd_chan}, {14'b0, code_of(e)});
               chk("R6", "pin a", {15'b0, sel_pin_a}, {15'b0, (b_cfg[5:4] == 2'd1) && lv});
               chk("R6", "pin b", {15'b0, sel_pin_b}, {15'b0, (b_cfg[5:4] == 2'd2) && lv});
               chk("R8", "gain", {14'b0, cmd_gain}, {14'b0, b_cfg[1:0]});
               chk("R8", "rate", {14'b0, cmd_rate}, {14'b0, b_cfg[3:2]});
               chk("R7", "settle gap ok", {15'b0, gap >= S + 1}, 16'd1);
               model_last = e;
               cur_ch = e;
            end
            cur_code = cmd_chan;
            cur_gain = cmd_gain;
            cur_rate = cmd_rate;
            busy = 1;
            dly = ACK_DLY;
            gap = 0;
         end else gap++;
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == 3'd0) b_cfg = d;
      if (a == 3'd1) b_mask = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic write_mid(input logic [2:0] a, input logic [15:0] d);
      while (!(busy && dly >= ACK_DLY - 1)) @(negedge clk);
      bus_write(a, d);
   endtask

   task automatic wait_acks(input int n);
      int target;
      target = ack_cnt + n;
      while (ack_cnt < target) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_results(input string rq);
      logic [15:0] v;
      for (int i = 0; i < 6; i++) begin
         bus_read(3'(i + 2), v);
         chk(rq, $sformatf("result ch%0d", i + 1), v, exp_res[i]);
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      bus_read(3'd0, v); chk("R1", "id after reset", v, 16'hAD00);
      bus_read(3'd1, v); chk("R1", "mask after reset", v, 16'h0000);
      check_results("R1");
      chk("R3", "req after reset", {15'b0, cmd_req}, 16'd0);
      chk("R6", "pins after reset", {14'b0, sel_pin_a, sel_pin_b}, 16'd0);
   endtask

   task automatic t_regs_idle();
      logic [15:0] v;
      int r0;
      bus_write(3'd0, 16'h0035);
      bus_read(3'd0, v); chk("R1", "config readback", v, 16'hAD35);
      bus_write(3'd0, 16'hFFFF);
      bus_read(3'd0, v); chk("R1", "reserved bits zero", v, 16'hAD3F);
      r0 = req_cnt;
      bus_write(3'd1, 16'hFFC0);
      bus_read(3'd1, v); chk("R1", "mask readback", v, 16'hFFC0);
      repeat (40) @(negedge clk);
      chk("R3", "no request with high-only mask", 16'(req_cnt - r0), 16'd0);
      bus_write(3'd1, 16'h0000);
      bus_write(3'd0, 16'h0018);
   endtask

   task automatic t_scan();
      bus_write(3'd1, 16'h002D);
      wait_acks(9);
      check_results("R4/R9");
   endtask

   task automatic t_routes();
      write_mid(3'd0, 16'h0028);
      write_mid(3'd1, 16'h003F);
      wait_acks(7);
      write_mid(3'd0, 16'h0008);
      wait_acks(7);
      write_mid(3'd0, 16'h0038);
      wait_acks(7);
      write_mid(3'd0, 16'h0018);
      wait_acks(2);
      check_results("R9");
   endtask

   task automatic t_signext();
      logic [15:0] v;
      stub_base = 16'h2A55;
      write_mid(3'd1, 16'h0007);
      write_mid(3'd0, 16'h0010);
      wait_acks(5);
      check_results("R10");
      bus_read(3'd2, v); chk("R10", "ch1 rate0", v, 16'hFA55);
      bus_read(3'd4, v); chk("R10", "ch3 raw", v, 16'h2A75);
      write_mid(3'd0, 16'h0014);
      wait_acks(5);
      bus_read(3'd2, v); chk("R10", "ch1 rate1", v, 16'hEA55);
      check_results("R10");
      write_mid(3'd0, 16'h0018);
      wait_acks(4);
      bus_read(3'd3, v); chk("R10", "ch2 rate2", v, 16'h2A65);
   endtask

   task automatic t_midchange();
      stub_base = 16'h0300;
      write_mid(3'd1, 16'h003F);
      wait_acks(2);
      write_mid(3'd0, 16'h001B);
      write_mid(3'd1, 16'h0020);
      wait_acks(3);
      check_results("R4/R8/R9");
   endtask

   task automatic t_stop();
      int r0;
      write_mid(3'd1, 16'h0000);
      wait_acks(1);
      r0 = req_cnt;
      repeat (60) @(negedge clk);
      chk("R3", "no request after mask cleared", 16'(req_cnt - r0), 16'd0);
      check_results("R4");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) exp_res[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs_idle();
      t_scan();
      t_routes();
      t_signext();
      t_midchange();
      t_stop();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule